// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the control pins of a single-data-rate SDRAM interface on every rising clock edge. It turns chip select, the three strobes, clock enable, bank select and the address bus into a named command, and splits the address into bank, row, column and flag fields. Alongside the decode it keeps the open or idle state and the open row of every bank. It also counts mode-register settle cycles and burst beats, so that it can close a bank when an auto-precharge burst ends.

Any command that breaks the sequencing rules raises a one-cycle violation pulse. A rejected command leaves all tracked state untouched. Separately, the block produces per-byte-lane enables from the data-mask pins. The read output enable follows the mask two clocks after sampling. The write enable applies the mask to the data of the same clock.

The block is meant to sit beside a memory model or a controller under test, as a protocol monitor and front-end decoder.

Top module: `sdcm_top`

## Requirements
- R1: Pins decode as {cs_n,ras_n,cas_n,we_n}. cs_n high gives INHIBIT (code 0). 0111 gives NOP (1), 0011 ACTIVE (2), 0101 READ (3), 0100 WRITE (4), 0110 BURST-STOP (5) and 0010 PRECHARGE (6). 0001 gives AUTO-REFRESH (7) when cke is high and SELF-REFRESH (8) when cke is low. 0000 gives MODE-LOAD (9). `cmd_code` shows the code one clock edge after sampling.
- R2: An accepted ACTIVE sets `bank_open[ba]` and stores addr[11:0] as that bank's row in `bank_rows[ba*12 +: 12]`.
- R3: For READ and WRITE, `cmd_col` is addr[8:0] and `cmd_flag` is addr[10]. A READ or WRITE to an idle bank raises `viol`.
- R4: PRECHARGE with addr[10] low closes only bank `ba`. With addr[10] high it closes every bank, whatever `ba` holds.
- R5: A refresh command, auto or self, issued while any bank is open raises `viol`. With all banks idle it is accepted.
- R6: Any command other than INHIBIT, NOP or the refresh encoding, sampled with cke low, raises `viol` and has no effect.
- R7: MODE-LOAD is accepted only with all banks idle, and then stores addr[11:0] in `mode_op`. After it, any command other than INHIBIT or NOP in the next TMRD-1 cycles (default TMRD=2) raises `viol` and is ignored.
- R8: ACTIVE to a bank that is already open raises `viol` and leaves that bank's stored row unchanged.
- R9: A READ or WRITE with addr[10] high closes its bank BURST_LEN-1 edges after the command edge (default BURST_LEN=4).
- R10: BURST-STOP ends the current burst at once, cancels any pending auto-precharge, and leaves the row open.
- R11: During a read burst, `rd_oe[i]` is the inverse of dqm[i] sampled two clocks earlier. Outside read bursts it is 0.
- R12: During a write burst, `wr_en[i]` is the inverse of dqm[i] in the same clock. Outside write bursts it is 0.
- R13: While rst_n is low, all banks are idle, the settle counter is clear, `rd_oe`, `wr_en` and `viol` are 0, and `cmd_code` reads INHIBIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| cke | input | 1 | Clock enable |
| ba | input | 2 | Bank select |
| addr | input | 12 | Address / op-code bus |
| dqm | input | 2 | Per-lane data mask |
| cmd_code | output | 4 | Registered command code |
| cmd_bank | output | 2 | Registered bank field |
| cmd_row | output | 12 | Registered row field |
| cmd_col | output | 9 | Registered column field |
| cmd_flag | output | 1 | Auto-precharge (READ/WRITE) or all-banks (PRECHARGE) |
| bank_open | output | 4 | Open status per bank |
| bank_rows | output | 48 | Open row per bank, 12 bits each |
| mode_op | output | 12 | Last accepted mode op-code |
| viol | output | 1 | Protocol violation pulse |
| rd_oe | output | 2 | Read output enable per lane |
| wr_en | output | 2 | Write enable per lane |

## Verification
On every cycle, the assertions check how the decoded command relates to the bank status it leaves behind. An accepted ACTIVE must leave its bank open, and an accepted READ or WRITE without auto-precharge must find its bank open. An accepted refresh or all-bank precharge must leave every bank idle. Banks must not move during the settle window, and a read enable may appear only two cycles after a read beat. The rest needs the bench's scenarios: the exact edge on which auto-precharge closes a bank, the cancelling of auto-precharge by BURST-STOP, the captured op-code and row values, the rejection of commands with cke low, and the lane-by-lane values of the two mask paths.

// File: rtl/sdcm_pkg.sv
package sdcm_pkg;
  typedef enum logic [3:0] {
    CMD_INH  = 4'd0,
    CMD_NOP  = 4'd1,
    CMD_ACT  = 4'd2,
    CMD_RD   = 4'd3,
    CMD_WR   = 4'd4,
    CMD_BST  = 4'd5,
    CMD_PRE  = 4'd6,
    CMD_AREF = 4'd7,
    CMD_SREF = 4'd8,
    CMD_LMR  = 4'd9
  } sd_cmd_e;
endpackage

// File: rtl/sdcm_decode.sv
module sdcm_decode #(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2,
  parameter int COL_W  = 9,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              cke,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  output sdcm_pkg::sd_cmd_e cmd_now,
  output logic [3:0]        cmd_q,
  output logic [BA_W-1:0]   bank_q,
  output logic [ADDR_W-1:0] row_q,
  output logic [COL_W-1:0]  col_q,
  output logic              flag_q
);
  import sdcm_pkg::*;

  sd_cmd_e cmd_d;
  logic    flag_d;

  always_comb begin
    if (cs_n) begin
      cmd_d = CMD_INH;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  cmd_d = CMD_NOP;
        3'b011:  cmd_d = CMD_ACT;
        3'b101:  cmd_d = CMD_RD;
        3'b100:  cmd_d = CMD_WR;
        3'b110:  cmd_d = CMD_BST;
        3'b010:  cmd_d = CMD_PRE;
        3'b001:  cmd_d = cke ? CMD_AREF : CMD_SREF;
        default: cmd_d = CMD_LMR;
      endcase
    end
    flag_d = addr[AP_BIT] &&
             (cmd_d == CMD_RD || cmd_d == CMD_WR || cmd_d == CMD_PRE);
  end

  assign cmd_now = cmd_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_INH;
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      bank_q <= ba;
      row_q  <= addr;
      col_q  <= addr[COL_W-1:0];
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/sdcm_bank_track.sv
module sdcm_bank_track #(
  parameter int ADDR_W    = 12,
  parameter int BA_W      = 2,
  parameter int AP_BIT    = 10,
  parameter int BURST_LEN = 4,
  parameter int TMRD      = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  sdcm_pkg::sd_cmd_e              cmd,
  input  logic                           cke,
  input  logic [BA_W-1:0]                ba,
  input  logic [ADDR_W-1:0]              addr,
  output logic [(1<<BA_W)-1:0]           open_o,
  output logic [(1<<BA_W)*ADDR_W-1:0]    rows_o,
  output logic [ADDR_W-1:0]              mode_o,
  output logic                           viol_o,
  output logic                           rd_phase,
  output logic                           wr_phase
);
  import sdcm_pkg::*;

  localparam int NBANK = 1 << BA_W;
  localparam int MW    = $clog2(TMRD + 1);
  localparam int LW    = $clog2(BURST_LEN + 1);

  logic [NBANK-1:0]  open_q, open_d;
  logic [ADDR_W-1:0] rows_q [NBANK];
  logic [ADDR_W-1:0] rows_d [NBANK];
  logic [ADDR_W-1:0] mode_q, mode_d;
  logic [MW-1:0]     mrd_q, mrd_d;
  logic [LW-1:0]     left_q, left_d;
  logic              ap_q, ap_d;
  logic              bwr_q, bwr_d;
  logic [BA_W-1:0]   abank_q, abank_d;
  logic              viol_q;
  logic              exec, err, acc, rw_cmd, bst_acc;

  always_comb begin
    exec   = (cmd != CMD_INH) && (cmd != CMD_NOP);
    rw_cmd = (cmd == CMD_RD) || (cmd == CMD_WR);
    err    = 1'b0;
    if (exec && mrd_q != '0) begin
      err = 1'b1;
    end else begin
      case (cmd)
        CMD_ACT:           err = !cke || open_q[ba];
        CMD_RD, CMD_WR:    err = !cke || !open_q[ba];
        CMD_BST, CMD_PRE:  err = !cke;
        CMD_AREF, CMD_SREF: err = |open_q;
        CMD_LMR:           err = !cke || (|open_q);
        default:           err = 1'b0;
      endcase
    end
    acc     = exec && !err;
    bst_acc = acc && (cmd == CMD_BST);
  end

  // next-state
  always_comb begin
    open_d  = open_q;
    rows_d  = rows_q;
    mode_d  = mode_q;
    mrd_d   = (mrd_q != '0) ? mrd_q - 1'b1 : '0;
    left_d  = left_q;
    ap_d    = ap_q;
    bwr_d   = bwr_q;
    abank_d = abank_q;

    if (left_q != '0) begin
      left_d = left_q - 1'b1;
      if (left_q == LW'(1)) begin
        if (ap_q && !bst_acc) open_d[abank_q] = 1'b0;
        ap_d = 1'b0;
      end
    end

    if (acc) begin
      case (cmd)
        CMD_ACT: begin
          open_d[ba] = 1'b1;
          rows_d[ba] = addr;
        end
        CMD_RD, CMD_WR: begin
          bwr_d   = (cmd == CMD_WR);
          abank_d = ba;
          if (BURST_LEN == 1) begin
            if (addr[AP_BIT]) open_d[ba] = 1'b0;
            left_d = '0;
            ap_d   = 1'b0;
          end else begin
            left_d = LW'(BURST_LEN - 1);
            ap_d   = addr[AP_BIT];
          end
        end
        CMD_BST: begin
          left_d = '0;
          ap_d   = 1'b0;
        end
        CMD_PRE: begin
          if (addr[AP_BIT]) open_d = '0;
          else              open_d[ba] = 1'b0;
        end
        CMD_LMR: begin
          mode_d = addr;
          mrd_d  = MW'(TMRD - 1);
        end
        default: ;
      endcase
    end

    rd_phase = 1'b0;
    wr_phase = 1'b0;
    if (acc && rw_cmd) begin
      rd_phase = (cmd == CMD_RD);
      wr_phase = (cmd == CMD_WR);
    end else if (left_q != '0 && !bst_acc) begin
      rd_phase = !bwr_q;
      wr_phase = bwr_q;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= '0;
      mode_q  <= '0;
      mrd_q   <= '0;
      left_q  <= '0;
      ap_q    <= 1'b0;
      bwr_q   <= 1'b0;
      abank_q <= '0;
      viol_q  <= 1'b0;
      for (int b = 0; b < NBANK; b++) rows_q[b] <= '0;
    end else begin
      open_q  <= open_d;
      mode_q  <= mode_d;
      mrd_q   <= mrd_d;
      left_q  <= left_d;
      ap_q    <= ap_d;
      bwr_q   <= bwr_d;
      abank_q <= abank_d;
      viol_q  <= err;
      for (int b = 0; b < NBANK; b++) rows_q[b] <= rows_d[b];
    end
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_rows
    assign rows_o[g*ADDR_W +: ADDR_W] = rows_q[g];
  end

  assign open_o = open_q;
  assign mode_o = mode_q;
  assign viol_o = viol_q;

  // R7
  mrd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_q != '0) |=> $stable(open_q));
endmodule

// File: rtl/sdcm_mask_pipe.sv
module sdcm_mask_pipe #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_phase,
  input  logic             wr_phase,
  input  logic [LANES-1:0] dqm,
  output logic [LANES-1:0] rd_oe,
  output logic [LANES-1:0] wr_en
);
  logic [LANES-1:0] s1_q, s1_d, s2_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      s1_d[i]  = rd_phase && !dqm[i];
      wr_en[i] = rst_n && wr_phase && !dqm[i];
    end

    // R11
    rd_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_oe[i] |-> $past(rd_phase, 2));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s1_q;
    end
  end

  assign rd_oe = s2_q;
endmodule

// File: rtl/sdcm_top.sv
module sdcm_top #(
  parameter int ADDR_W    = 12,
  parameter int BA_W      = 2,
  parameter int COL_W     = 9,
  parameter int AP_BIT    = 10,
  parameter int LANES     = 2,
  parameter int BURST_LEN = 4,
  parameter int TMRD      = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cs_n,
  input  logic                        ras_n,
  input  logic                        cas_n,
  input  logic                        we_n,
  input  logic                        cke,
  input  logic [BA_W-1:0]             ba,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [LANES-1:0]            dqm,
  output logic [3:0]                  cmd_code,
  output logic [BA_W-1:0]             cmd_bank,
  output logic [ADDR_W-1:0]           cmd_row,
  output logic [COL_W-1:0]            cmd_col,
  output logic                        cmd_flag,
  output logic [(1<<BA_W)-1:0]        bank_open,
  output logic [(1<<BA_W)*ADDR_W-1:0] bank_rows,
  output logic [ADDR_W-1:0]           mode_op,
  output logic                        viol,
  output logic [LANES-1:0]            rd_oe,
  output logic [LANES-1:0]            wr_en
);
  import sdcm_pkg::*;

  sd_cmd_e cmd_now;
  logic    rd_phase, wr_phase;

  sdcm_decode #(.ADDR_W(ADDR_W), .BA_W(BA_W), .COL_W(COL_W), .AP_BIT(AP_BIT)) u_dec (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .ba(ba), .addr(addr), .cmd_now(cmd_now),
    .cmd_q(cmd_code), .bank_q(cmd_bank), .row_q(cmd_row), .col_q(cmd_col),
    .flag_q(cmd_flag)
  );

  sdcm_bank_track #(.ADDR_W(ADDR_W), .BA_W(BA_W), .AP_BIT(AP_BIT),
                    .BURST_LEN(BURST_LEN), .TMRD(TMRD)) u_trk (
    .clk(clk), .rst_n(rst_n), .cmd(cmd_now), .cke(cke), .ba(ba), .addr(addr),
    .open_o(bank_open), .rows_o(bank_rows), .mode_o(mode_op), .viol_o(viol),
    .rd_phase(rd_phase), .wr_phase(wr_phase)
  );

  sdcm_mask_pipe #(.LANES(LANES)) u_msk (
    .clk(clk), .rst_n(rst_n), .rd_phase(rd_phase), .wr_phase(wr_phase),
    .dqm(dqm), .rd_oe(rd_oe), .wr_en(wr_en)
  );

  // R2
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_ACT && !viol) |-> bank_open[cmd_bank]);

  // R3
  rw_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_code == CMD_RD || cmd_code == CMD_WR) && !viol && !cmd_flag)
      |-> bank_open[cmd_bank]);

  // R4
  pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_PRE && !viol && cmd_flag) |-> (bank_open == '0));

  // R5
  ref_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_code == CMD_AREF || cmd_code == CMD_SREF) && !viol)
      |-> (bank_open == '0));
endmodule

// File: tb/sdcm_top_tb.sv
`timescale 1ns/1ps
module sdcm_top_tb;
  localparam logic [3:0] C_INH = 4'b1111, C_NOP = 4'b0111, C_ACT = 4'b0011,
                         C_RD  = 4'b0101, C_WR  = 4'b0100, C_BST = 4'b0110,
                         C_PRE = 4'b0010, C_REF = 4'b0001, C_LMR = 4'b0000;

  logic clk, rst_n, cs_n, ras_n, cas_n, we_n, cke;
  logic [1:0]  ba, dqm;
  logic [11:0] addr;
  logic [3:0]  cmd_code;
  logic [1:0]  cmd_bank;
  logic [11:0] cmd_row;
  logic [8:0]  cmd_col;
  logic        cmd_flag, viol;
  logic [3:0]  bank_open;
  logic [47:0] bank_rows;
  logic [11:0] mode_op;
  logic [1:0]  rd_oe, wr_en, wr_seen;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  sdcm_top u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .ba(ba), .addr(addr), .dqm(dqm),
    .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .cmd_col(cmd_col), .cmd_flag(cmd_flag), .bank_open(bank_open),
    .bank_rows(bank_rows), .mode_op(mode_op), .viol(viol),
    .rd_oe(rd_oe), .wr_en(wr_en)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] c, input logic k, input logic [1:0] b,
                      input logic [11:0] a, input logic [1:0] m);
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = c;
    cke = k; ba = b; addr = a; dqm = m;
    #2 wr_seen = wr_en;
    @(posedge clk);
    #1;
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) step(C_NOP, 1, 0, 0, 0);
  endtask

  task automatic t_reset();
    rst_n = 0; {cs_n, ras_n, cas_n, we_n} = C_INH; cke = 1; ba = 0; addr = 0; dqm = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R13 bank_open", bank_open, 0);
    chk("R13 cmd_code", cmd_code, 0);
    chk("R13 viol", viol, 0);
    chk("R13 rd_oe", rd_oe, 0);
    chk("R13 wr_en", wr_en, 0);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_decode();
    step(C_INH, 1, 0, 0, 0); chk("R1 inhibit", cmd_code, 0);
    step(C_NOP, 1, 0, 0, 0); chk("R1 nop", cmd_code, 1);
    step(C_BST, 1, 0, 0, 0); chk("R1 bst", cmd_code, 5);
    step(C_PRE, 1, 0, 12'h400, 0); chk("R1 pre", cmd_code, 6);
    step(C_REF, 1, 0, 0, 0); chk("R1 aref", cmd_code, 7);
    step(C_REF, 0, 0, 0, 0); chk("R1 sref", cmd_code, 8);
    chk("R5 sref idle ok", viol, 0);
    step(C_ACT, 1, 0, 12'h005, 0); chk("R1 act", cmd_code, 2);
    step(C_RD, 1, 0, 12'h013, 0); chk("R1 rd", cmd_code, 3);
    chk("R3 col", cmd_col, 9'h013);
    step(C_WR, 1, 0, 12'h021, 0); chk("R1 wr", cmd_code, 4);
    step(C_PRE, 1, 0, 12'h400, 0);
    step(C_LMR, 1, 0, 12'h2A7, 0); chk("R1 lmr", cmd_code, 9);
    chk("R7 op captured", mode_op, 12'h2A7);
    chk("R7 lmr idle ok", viol, 0);
    nop(4);
  endtask

  task automatic t_active();
    step(C_ACT, 1, 2, 12'hABC, 0);
    chk("R2 open", bank_open, 4'b0100);
    chk("R2 row", bank_rows[2*12 +: 12], 12'hABC);
    step(C_ACT, 1, 2, 12'h111, 0);
    chk("R8 viol", viol, 1);
    chk("R8 row kept", bank_rows[2*12 +: 12], 12'hABC);
    step(C_RD, 1, 1, 12'h000, 0);
    chk("R3 idle read viol", viol, 1);
    step(C_PRE, 1, 2, 12'h000, 0);
    chk("R4 single close", bank_open, 0);
    nop(1);
  endtask

  task automatic t_prech_all();
    step(C_ACT, 1, 0, 1, 0); step(C_ACT, 1, 1, 2, 0); step(C_ACT, 1, 3, 3, 0);
    chk("R2 three open", bank_open, 4'b1011);
    step(C_PRE, 1, 3, 12'h000, 0);
    chk("R4 only bank3", bank_open, 4'b0011);
    step(C_PRE, 1, 2, 12'h400, 0);
    chk("R4 all closed", bank_open, 0);
    chk("R3 flag for pre", cmd_flag, 1);
  endtask

  task automatic t_refresh();
    step(C_ACT, 1, 0, 7, 0);
    step(C_REF, 1, 0, 0, 0); chk("R5 aref open viol", viol, 1);
    step(C_REF, 0, 0, 0, 0); chk("R5 sref open viol", viol, 1);
    step(C_PRE, 1, 0, 12'h400, 0);
    step(C_REF, 1, 0, 0, 0); chk("R5 aref idle ok", viol, 0);
  endtask

  task automatic t_cke();
    step(C_ACT, 0, 1, 12'h055, 0);
    chk("R6 cke low viol", viol, 1);
    chk("R6 no open", bank_open, 0);
    step(C_LMR, 0, 0, 12'h0FF, 0);
    chk("R6 lmr cke low viol", viol, 1);
    chk("R6 op unchanged", mode_op, 12'h2A7);
  endtask

  task automatic t_lmr();
    step(C_ACT, 1, 0, 1, 0);
    step(C_LMR, 1, 0, 12'h0AA, 0);
    chk("R7 lmr open viol", viol, 1);
    chk("R7 op unchanged", mode_op, 12'h2A7);
    step(C_PRE, 1, 0, 12'h400, 0);
    step(C_LMR, 1, 0, 12'h033, 0);
    chk("R7 op", mode_op, 12'h033);
    step(C_ACT, 1, 1, 5, 0);
    chk("R7 blocked viol", viol, 1);
    chk("R7 blocked no open", bank_open, 0);
    step(C_ACT, 1, 1, 5, 0);
    chk("R7 after settle", viol, 0);
    chk("R7 after settle open", bank_open, 4'b0010);
    step(C_PRE, 1, 0, 12'h400, 0);
  endtask

  task automatic t_autopre();
    step(C_ACT, 1, 1, 12'h0F0, 0);
    step(C_RD, 1, 1, 12'h405, 0);
    chk("R3 ap flag", cmd_flag, 1);
    chk("R9 open at cmd", bank_open[1], 1);
    step(C_NOP, 1, 0, 0, 0); chk("R9 open k+1", bank_open[1], 1);
    step(C_NOP, 1, 0, 0, 0); chk("R9 open k+2", bank_open[1], 1);
    step(C_NOP, 1, 0, 0, 0); chk("R9 closed k+3", bank_open[1], 0);
    nop(2);
  endtask

  task automatic t_bterm();
    step(C_ACT, 1, 3, 12'h123, 0);
    step(C_WR, 1, 3, 12'h400, 2'b01);
    chk("R12 wr same clock", wr_seen, 2'b10);
    step(C_NOP, 1, 0, 0, 2'b10);
    chk("R12 wr beat 2", wr_seen, 2'b01);
    step(C_BST, 1, 0, 0, 2'b00);
    chk("R10 bst stops write", wr_seen, 2'b00);
    nop(4);
    chk("R12 idle no write", wr_seen, 2'b00);
    chk("R10 row stays open", bank_open[3], 1);
    step(C_PRE, 1, 0, 12'h400, 0);
  endtask

  task automatic t_read_mask();
    nop(4);
    step(C_ACT, 1, 0, 12'h010, 0);
    step(C_RD, 1, 0, 12'h000, 2'b01);
    chk("R11 before lag", rd_oe, 2'b00);
    chk("R12 no wr on read", wr_seen, 2'b00);
    step(C_NOP, 1, 0, 0, 2'b10); chk("R11 beat1", rd_oe, 2'b10);
    step(C_NOP, 1, 0, 0, 2'b00); chk("R11 beat2", rd_oe, 2'b01);
    step(C_NOP, 1, 0, 0, 2'b11); chk("R11 beat3", rd_oe, 2'b11);
    step(C_NOP, 1, 0, 0, 2'b00); chk("R11 beat4", rd_oe, 2'b00);
    step(C_NOP, 1, 0, 0, 2'b00); chk("R11 after burst", rd_oe, 2'b00);
    step(C_PRE, 1, 0, 12'h400, 0);
  endtask

  initial begin
    t_reset();
    t_decode();
    t_active();
    t_prech_all();
    t_refresh();
    t_cke();
    t_lmr();
    t_autopre();
    t_bterm();
    t_read_mask();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule